// File: doc/BRIEF.md
# Key-Armed Watchdog Timer

This block is a watchdog for an 8-bit microcontroller core. After a system reset it sits idle and never asks for a reset by itself. Software brings it to life by writing an ordered pair of key bytes to one dedicated restart register. It keeps it alive by repeating that same pair before the counter runs out. The block watches the core's register write port and a cycle-enable tick. While armed, a counter advances once per tick. When that counter wraps from all ones to zero, the block raises a one-cycle reset request to the CPU and drops back to idle.

Two small state machines do the work. The key machine has the states KEY_IDLE and KEY_HALF. A write of 0x1E to the restart address moves it from KEY_IDLE to KEY_HALF (transition "first key"). The next write to that address always returns it to KEY_IDLE. If that write carries 0xE1, the return is "key complete" and a key pulse is produced. Any other value makes the return "key abort".

The run machine has the states RUN_OFF, RUN_ACTIVE and RUN_FIRE:
- "arm" (RUN_OFF to RUN_ACTIVE) happens on a key pulse and clears the counter.
- "restart" (RUN_ACTIVE to RUN_ACTIVE) happens on a key pulse and also clears the counter.
- "expire" (RUN_ACTIVE to RUN_FIRE) happens on a tick with the counter at all ones.
- "disarm" (RUN_FIRE to RUN_OFF) is unconditional and takes one clock.

The request output is high exactly while the machine is in RUN_FIRE. No register write leads out of RUN_ACTIVE.

Top module: `keyed_watchdog`

## Requirements
- R1: After rst_n is deasserted, the watchdog is in RUN_OFF with cpu_rst_req low. Without a key sequence it never raises cpu_rst_req, however many ticks arrive.
- R2: Only writes with reg_addr equal to RESTART_ADDR (default 0xB7) are examined by the key logic. A write to any other address neither starts a sequence nor disturbs a pending first key.
- R3: The key is 0x1E followed by 0xE1, and the 0xE1 must be the very next write to the restart address. Any other value in second place, including 0x1E again, discards the pending first key. The reverse order does nothing.
- R4: A completed key in RUN_OFF arms the watchdog with the counter at zero, on the clock edge that takes the 0xE1 write. With tick held high from the following edge on, cpu_rst_req first goes high after the 2^CNT_W-th such edge (default CNT_W = 14).
- R5: A completed key in RUN_ACTIVE restarts the count from zero, so expiry moves to 2^CNT_W ticks after the restart edge.
- R6: The counter advances only on clock edges where tick is high. Edges with tick low neither advance nor clear it.
- R7: On expiry, cpu_rst_req is high for exactly one clock cycle, after which the watchdog is back in RUN_OFF. It then stays silent until a new key arms it.
- R8: Once armed, no register write of any address or value stops the watchdog. Only rst_n returns it to RUN_OFF.
- R9: If the 0xE1 write lands on the same edge as the tick that would expire the counter, the restart wins. No request is raised and the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| tick | input | 1 | Cycle enable, one per machine cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | 8 | Register write data |
| cpu_rst_req | output | 1 | One-cycle CPU reset request |

## Verification
Restart and expiry are the two functions that can fall on the same clock edge. The bench provokes this by sending the first key byte during the last tick before wrap, then placing the 0xE1 write on exactly the edge whose tick meets the all-ones counter. The result is judged by checking that cpu_rst_req stays low at that point. The bench also checks that the request appears only a full 2^CNT_W ticks later, which shows the counter was cleared rather than wrapped.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam logic [7:0] KEY_FIRST  = 8'h1E;
    localparam logic [7:0] KEY_SECOND = 8'hE1;

    typedef enum logic [0:0] {
        KEY_IDLE = 1'b0,
        KEY_HALF = 1'b1
    } key_state_e;

    typedef enum logic [1:0] {
        RUN_OFF    = 2'd0,
        RUN_ACTIVE = 2'd1,
        RUN_FIRE   = 2'd2
    } run_state_e;

endpackage

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
    import wdg_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] RESTART_ADDR = 8'hB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic              key_ok
);

    key_state_e state_q;
    key_state_e state_d;
    logic       hit;

    assign hit = reg_wr && (reg_addr == RESTART_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: if (hit && reg_wdata == KEY_FIRST) state_d = KEY_HALF; // first key
            KEY_HALF: if (hit) state_d = KEY_IDLE;                            // complete or abort
            default:  state_d = KEY_IDLE;
        endcase
    end

    always_comb begin
        key_ok = 1'b0;
        unique case (state_q)
            KEY_IDLE: key_ok = 1'b0;
            KEY_HALF: key_ok = hit && (reg_wdata == KEY_SECOND);
            default:  key_ok = 1'b0;
        endcase
    end

    // R2: writes elsewhere leave the key state untouched
    a_r2_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr || reg_addr != RESTART_ADDR) |=> $stable(state_q));

    // R3: any restart-address write while half-keyed ends the sequence
    a_r3_second_write_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_HALF && hit) |=> (state_q == KEY_IDLE));

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic tick,
    output logic expire
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clear)          cnt_q <= '0;
        else if (enable && tick) cnt_q <= cnt_q + 1'b1;
    end

    // clear has priority over wrap (R9)
    assign expire = enable && tick && !clear && (cnt_q == CNT_MAX);

    // R6: no tick, no clear -> counter holds
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt_q));

    // R4/R5: a clear leaves the counter at zero
    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/wdg_run_fsm.sv
module wdg_run_fsm
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_ok,
    input  logic expire,
    output logic count_clear,
    output logic count_en,
    output logic cpu_rst_req
);

    run_state_e state_q;
    run_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_OFF:    if (key_ok) state_d = RUN_ACTIVE;        // arm
            RUN_ACTIVE: if (key_ok) state_d = RUN_ACTIVE;        // restart
                        else if (expire) state_d = RUN_FIRE;     // expire
            RUN_FIRE:   state_d = RUN_OFF;                       // disarm
            default:    state_d = RUN_OFF;
        endcase
    end

    always_comb begin
        count_clear = 1'b0;
        count_en    = 1'b0;
        cpu_rst_req = 1'b0;
        unique case (state_q)
            RUN_OFF:    count_clear = key_ok;
            RUN_ACTIVE: begin
                count_clear = key_ok;
                count_en    = 1'b1;
            end
            RUN_FIRE:   cpu_rst_req = 1'b1;
            default:    cpu_rst_req = 1'b0;
        endcase
    end

    // R7: the request lasts one cycle and is followed by RUN_OFF
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_req |=> (!cpu_rst_req && state_q == RUN_OFF));

    // R8: only expiry leaves RUN_ACTIVE
    a_r8_no_soft_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_ACTIVE && !expire) |=> (state_q == RUN_ACTIVE));

    // R9: a key on an active watchdog suppresses the request
    a_r9_key_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_ACTIVE && key_ok) |=> !cpu_rst_req);

    // R1: leaving RUN_OFF needs a key
    a_r1_off_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_OFF && !key_ok) |=> (state_q == RUN_OFF));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int                ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] RESTART_ADDR = 8'hB7,
    parameter int                CNT_W        = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic              cpu_rst_req
);

    logic key_ok;
    logic expire;
    logic count_clear;
    logic count_en;

    wdg_key_fsm #(
        .ADDR_W       (ADDR_W),
        .RESTART_ADDR (RESTART_ADDR)
    ) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .key_ok    (key_ok)
    );

    wdg_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (count_clear),
        .enable (count_en),
        .tick   (tick),
        .expire (expire)
    );

    wdg_run_fsm u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_ok      (key_ok),
        .expire      (expire),
        .count_clear (count_clear),
        .count_en    (count_en),
        .cpu_rst_req (cpu_rst_req)
    );

    // R4: a request can only follow a tick
    a_r4_req_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_req) |-> $past(tick));

endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;

    localparam int          TB_CNT_W = 10;
    localparam int          PERIOD   = 1 << TB_CNT_W;
    localparam logic [7:0]  RA       = 8'hB7;
    localparam logic [7:0]  OA       = 8'hB6;

    typedef struct packed {
        logic [1:0]      n;
        logic [2:0][7:0] a;
        logic [2:0][7:0] d;
        logic            arm;
    } vec_t;

    function automatic vec_t mk(logic [1:0] n,
                                logic [7:0] a0, logic [7:0] d0,
                                logic [7:0] a1, logic [7:0] d1,
                                logic [7:0] a2, logic [7:0] d2,
                                logic arm);
        vec_t v;
        v.n   = n;
        v.a   = {a2, a1, a0};
        v.d   = {d2, d1, d0};
        v.arm = arm;
        return v;
    endfunction

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        mk(2'd2, RA, 8'h1E, RA, 8'hE1, RA, 8'h00, 1'b1), // R4 plain key
        mk(2'd2, RA, 8'hE1, RA, 8'h1E, RA, 8'h00, 1'b0), // R3 reversed
        mk(2'd3, RA, 8'h1E, OA, 8'hE1, RA, 8'hE1, 1'b1), // R2 foreign write between
        mk(2'd3, RA, 8'h1E, RA, 8'h55, RA, 8'hE1, 1'b0), // R3 wrong second byte
        mk(2'd3, RA, 8'h1E, RA, 8'h1E, RA, 8'hE1, 1'b0), // R3 repeated first byte
        mk(2'd2, OA, 8'h1E, OA, 8'hE1, RA, 8'h00, 1'b0), // R2 key at other address
        mk(2'd3, RA, 8'h00, RA, 8'h1E, RA, 8'hE1, 1'b1)  // R3 junk then key
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       cpu_rst_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    keyed_watchdog #(
        .ADDR_W       (8),
        .RESTART_ADDR (RA),
        .CNT_W        (TB_CNT_W)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .cpu_rst_req (cpu_rst_req)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: cpu_rst_req=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        tick   = 1'b0;
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_fire(input string req);
        ticks(PERIOD - 1);
        check(req, cpu_rst_req, 1'b0);
        ticks(1);
        check(req, cpu_rst_req, 1'b1);
        ticks(1);
        check(req, cpu_rst_req, 1'b0);
    endtask

    task automatic arm();
        tick = 1'b0;
        wr(RA, 8'h1E);
        wr(RA, 8'hE1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state and silence without key
        do_reset();
        check("R1", cpu_rst_req, 1'b0);
        ticks(3 * PERIOD);
        check("R1", cpu_rst_req, 1'b0);

        // vector table: R2 / R3 / R4
        for (int i = 0; i < NV; i++) begin
            do_reset();
            for (int w = 0; w < int'(VECS[i].n); w++) wr(VECS[i].a[w], VECS[i].d[w]);
            ticks(PERIOD - 1);
            check("R2/R3/R4 table", cpu_rst_req, 1'b0);
            ticks(1);
            check("R2/R3/R4 table", cpu_rst_req, VECS[i].arm);
        end

        // R5: restart while running delays expiry
        do_reset();
        arm();
        ticks(600);
        tick = 1'b0;
        wr(RA, 8'h1E);
        wr(RA, 8'hE1);
        expect_fire("R5");

        // R6: ticks low hold the count
        do_reset();
        arm();
        ticks(512);
        tick = 1'b0;
        repeat (300) @(negedge clk);
        check("R6", cpu_rst_req, 1'b0);
        ticks(PERIOD - 512 - 1);
        check("R6", cpu_rst_req, 1'b0);
        ticks(1);
        check("R6", cpu_rst_req, 1'b1);

        // R7: one pulse, then disarmed, then re-armable
        do_reset();
        arm();
        expect_fire("R7");
        ticks(2 * PERIOD);
        check("R7", cpu_rst_req, 1'b0);
        arm();
        expect_fire("R7");

        // R8: writes cannot stop it
        do_reset();
        arm();
        tick = 1'b1;
        wr(RA, 8'h00);
        wr(RA, 8'hFF);
        wr(OA, 8'h00);
        wr(RA, 8'h1E);
        wr(RA, 8'h1F);
        ticks(PERIOD - 5 - 1);
        check("R8", cpu_rst_req, 1'b0);
        ticks(1);
        check("R8", cpu_rst_req, 1'b1);

        // R8: system reset does stop it
        do_reset();
        arm();
        ticks(500);
        do_reset();
        ticks(2 * PERIOD);
        check("R8", cpu_rst_req, 1'b0);

        // R9: key completes on the expiring tick
        do_reset();
        arm();
        ticks(PERIOD - 2);
        wr(RA, 8'h1E);
        wr(RA, 8'hE1);
        check("R9", cpu_rst_req, 1'b0);
        ticks(PERIOD - 1);
        check("R9", cpu_rst_req, 1'b0);
        ticks(1);
        check("R9", cpu_rst_req, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule